// File: doc/BRIEF.md
# Cursor and Crosshair Pixel Overlay

This block produces a hardware cursor and a crosshair for a raster display. Every clock it takes the raster position of the pixel now being generated and compares it with a programmed cursor position and a crosshair window. The cursor is a 64 by 64 image with two bits per pixel. The image sits in an external pattern RAM, and the block reads that RAM through a plain synchronous read port. The crosshair is a pair of bands, one vertical and one horizontal, each 1, 3, 5 or 7 pixels thick. The bands cross at the centre of the cursor box, and they are clipped to a rectangular window.

A small command field switches the cursor and the crosshair on or off and sets the band thickness. It also chooses how the two shapes are combined. In OR mode each shape appears on its own. In AND mode each shape appears only where the two overlap. A two-bit multiplex-ratio field only selects the fixed horizontal offset used to place the cursor, and the pixel stream itself is always produced at one pixel per clock. The block's outputs go to the pixel path that mixes overlay colours into the video.

Top module: `curs_overlay`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `cur_pix` and `xhair` are both 0 after that edge.
- R2: `cur_pix` and `xhair` show the result for the inputs `pix_x`, `pix_y`, `cmd` and the position and window fields sampled two rising edges earlier. `ram_data` must carry the word addressed by `ram_addr` one clock after that address.
- R3: The cursor box is 64 by 64 pixels. Its left column is `cur_x - K` and its top row is `cur_y - 32`. K is 37 when `cmd[3:2]` is 00 or 11, 52 when it is 01, and 57 when it is 10. All of this is computed without wrap-around.
- R4: For a pixel at box offset (dx, dy), `ram_addr` equals dy*8 + dx/8, combinationally from the current inputs. The pixel value is bits [15-2*(dx mod 8) : 14-2*(dx mod 8)] of the returned word, so the leftmost pixel of a word sits in the top two bits.
- R5: The cursor plane value is that pattern field when `cmd[6]` is 1 and the pixel lies inside the box, and 0 otherwise.
- R6: When `cmd[5]` is 1, a pixel is on the crosshair if it lies within h columns of box column 32 or within h rows of box row 32, where h = `cmd[1:0]`. The band is therefore 2h+1 pixels thick. When `cmd[5]` is 0 there is no crosshair.
- R7: A crosshair pixel also needs `win_x <= pix_x < win_x + win_w` and `win_y <= pix_y < win_y + win_h`. A zero width or a zero height gives no crosshair at all.
- R8: With `cmd[4]` = 1 (OR mode), `cur_pix` is the cursor plane value and `xhair` is the crosshair plane, each independent of the other.
- R9: With `cmd[4]` = 0 (AND mode), `cur_pix` is the cursor plane value only on crosshair pixels and 0 elsewhere. `xhair` is 1 only on crosshair pixels whose cursor plane value is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_x | input | 12 | Raster column of the current pixel |
| pix_y | input | 12 | Raster line of the current pixel |
| cmd | input | 7 | Command: [6] cursor on, [5] crosshair on, [4] OR/AND select, [3:2] mux ratio, [1:0] thickness |
| cur_x | input | 12 | Programmed cursor column |
| cur_y | input | 12 | Programmed cursor line |
| win_x | input | 12 | Crosshair window left column |
| win_y | input | 12 | Crosshair window top line |
| win_w | input | 12 | Crosshair window width |
| win_h | input | 12 | Crosshair window height |
| ram_addr | output | 9 | Pattern RAM word address |
| ram_data | input | 16 | Pattern RAM word, one clock after the address |
| cur_pix | output | 2 | Two-bit cursor pixel value |
| xhair | output | 1 | Crosshair pixel flag |

## Verification
The only internal state is one pipeline stage, which holds the box hit, the pixel index within the word, the crosshair hit and the combine mode. A wrong value in that stage reaches `cur_pix` or `xhair` on the very next clock, as a wrongly placed edge, a pixel swapped within a word, or a band of the wrong thickness. Scans that sweep every pixel around the box, plus randomized positions and commands, show any fault in placement or addressing within one line of the sweep. A fault in the AND/OR path or in stage alignment shows up within a few cycles of a command change.

// File: rtl/curs_ovl_pkg.sv
// Package: shared command decode and placement constants for the cursor overlay.
// Assumes the command field layout given in the brief (bits 6..0).
package curs_ovl_pkg;

    // Horizontal placement offsets per multiplex-ratio setting, vertical offset.
    localparam int unsigned XOFF_R1 = 37;
    localparam int unsigned XOFF_R4 = 52;
    localparam int unsigned XOFF_R5 = 57;
    localparam int unsigned YOFF    = 32;

    typedef enum logic [1:0] {
        MUX_R1  = 2'b00,
        MUX_R4  = 2'b01,
        MUX_R5  = 2'b10,
        MUX_RSV = 2'b11
    } mux_e;

    typedef struct packed {
        logic       cur_on;
        logic       xh_on;
        logic       or_mode;
        mux_e       mux;
        logic [1:0] half;
    } ovl_cmd_t;

    // Split the raw command field into named controls.
    function automatic ovl_cmd_t decode_cmd(input logic [6:0] raw);
        ovl_cmd_t c;
        c.cur_on  = raw[6];
        c.xh_on   = raw[5];
        c.or_mode = raw[4];
        c.mux     = mux_e'(raw[3:2]);
        c.half    = raw[1:0];
        return c;
    endfunction

    // Horizontal offset for a ratio setting; the reserved code behaves as 1:1.
    function automatic int unsigned x_offset(input mux_e m);
        case (m)
            MUX_R4:  return XOFF_R4;
            MUX_R5:  return XOFF_R5;
            default: return XOFF_R1;
        endcase
    endfunction

endpackage

// File: rtl/curs_place.sv
// Module: curs_place
// Computes the signed offset of the current raster pixel from the cursor
// box origin, the in-box flag, the pattern RAM word address and the pixel
// index inside that word. Purely combinational.
// Assumes DIM and PPW are powers of two and SW leaves room for the sign.
module curs_place #(
    parameter int POS_W  = 12,
    parameter int DIM    = 64,
    parameter int PPW    = 8,
    parameter int SW     = POS_W + 2,
    parameter int ADDR_W = 9
) (
    input  logic [POS_W-1:0]         pix_x,
    input  logic [POS_W-1:0]         pix_y,
    input  logic [POS_W-1:0]         cur_x,
    input  logic [POS_W-1:0]         cur_y,
    input  curs_ovl_pkg::mux_e       mux,
    output logic signed [SW-1:0]     dx,
    output logic signed [SW-1:0]     dy,
    output logic                     in_box,
    output logic [ADDR_W-1:0]        addr,
    output logic [$clog2(PPW)-1:0]   sub
);
    localparam int LOG_DIM = $clog2(DIM);
    localparam int LOG_PPW = $clog2(PPW);
    localparam logic signed [SW-1:0] DIM_S = SW'(DIM);
    localparam logic signed [SW-1:0] YOFF_S = SW'(curs_ovl_pkg::YOFF);

    logic signed [SW-1:0] px_s, py_s, cx_s, cy_s, xoff_s;

    // Widen positions to signed form so box offsets never wrap.
    always_comb begin
        px_s   = $signed({2'b00, pix_x});
        py_s   = $signed({2'b00, pix_y});
        cx_s   = $signed({2'b00, cur_x});
        cy_s   = $signed({2'b00, cur_y});
        xoff_s = SW'(curs_ovl_pkg::x_offset(mux));
    end

    // Offset of the pixel from the box origin (origin = cursor minus offset).
    always_comb begin
        dx = px_s + xoff_s - cx_s;
        dy = py_s + YOFF_S - cy_s;
    end

    // Box hit test and pattern addressing (row-major words, 8 per row).
    always_comb begin
        in_box = (dx >= 0) && (dx < DIM_S) && (dy >= 0) && (dy < DIM_S);
        addr   = {dy[LOG_DIM-1:0], dx[LOG_DIM-1:LOG_PPW]};
        sub    = dx[LOG_PPW-1:0];
    end

endmodule

// File: rtl/curs_xhair.sv
// Module: curs_xhair
// Decides whether the current pixel lies on the crosshair bands around the
// box centre and inside the clipping window. Enable is applied by the caller.
// Assumes dx/dy come from curs_place for the same pixel.
module curs_xhair #(
    parameter int POS_W = 12,
    parameter int DIM   = 64,
    parameter int SW    = POS_W + 2
) (
    input  logic [POS_W-1:0]     pix_x,
    input  logic [POS_W-1:0]     pix_y,
    input  logic signed [SW-1:0] dx,
    input  logic signed [SW-1:0] dy,
    input  logic [1:0]           half,
    input  logic [POS_W-1:0]     win_x,
    input  logic [POS_W-1:0]     win_y,
    input  logic [POS_W-1:0]     win_w,
    input  logic [POS_W-1:0]     win_h,
    output logic                 hit
);
    localparam logic signed [SW-1:0] CTR_S = SW'(DIM / 2);

    logic signed [SW-1:0] hdx, hdy, h_s;
    logic                 near_x, near_y;
    logic [POS_W:0]       rel_x, rel_y;
    logic                 in_wx, in_wy;

    // Distance to the centre lines, compared against the half thickness.
    always_comb begin
        h_s    = SW'(half);
        hdx    = dx - CTR_S;
        hdy    = dy - CTR_S;
        near_x = (hdx >= -h_s) && (hdx <= h_s);
        near_y = (hdy >= -h_s) && (hdy <= h_s);
    end

    // Window clipping by difference, so win_x + win_w never overflows.
    always_comb begin
        rel_x = {1'b0, pix_x} - {1'b0, win_x};
        rel_y = {1'b0, pix_y} - {1'b0, win_y};
        in_wx = (pix_x >= win_x) && (rel_x < {1'b0, win_w});
        in_wy = (pix_y >= win_y) && (rel_y < {1'b0, win_h});
    end

    // Either band counts, but only inside the window.
    always_comb hit = (near_x || near_y) && in_wx && in_wy;

endmodule

// File: rtl/curs_mix.sv
// Module: curs_mix
// Second pipeline stage: extracts the pixel field from the RAM word that
// arrives one clock after its address, applies the cursor gate, combines
// cursor and crosshair by OR or AND rules and registers the outputs.
// Assumes the leftmost pixel of a word sits in its top bits.
module curs_mix #(
    parameter int PIX_BITS = 2,
    parameter int WORD_W   = 16,
    parameter int PPW      = WORD_W / PIX_BITS
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     s_cur,
    input  logic [$clog2(PPW)-1:0]   s_sub,
    input  logic                     s_xh,
    input  logic                     s_or,
    input  logic [WORD_W-1:0]        ram_data,
    output logic [PIX_BITS-1:0]      cur_pix,
    output logic                     xhair
);
    localparam int LOG_PPW = $clog2(PPW);

    logic [PIX_BITS-1:0] fld, cval, pix_d;
    logic                xh_d;

    // Select the field of the addressed pixel, most significant first.
    always_comb begin
        fld = '0;
        for (int i = 0; i < PPW; i++) begin
            if (s_sub == LOG_PPW'(i)) begin
                fld = ram_data[WORD_W-1-i*PIX_BITS -: PIX_BITS];
            end
        end
    end

    // Gate the cursor plane and apply the combine rule.
    always_comb begin
        cval = s_cur ? fld : '0;
        if (s_or) begin
            pix_d = cval;
            xh_d  = s_xh;
        end else begin
            pix_d = s_xh ? cval : '0;
            xh_d  = s_xh && (cval != '0);
        end
    end

    // Output register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_pix <= '0;
            xhair   <= 1'b0;
        end else begin
            cur_pix <= pix_d;
            xhair   <= xh_d;
        end
    end

endmodule

// File: rtl/curs_overlay.sv
// Module: curs_overlay (top)
// Per-pixel cursor and crosshair overlay. Stage A compares the raster
// position with the cursor box and window and issues the pattern RAM
// address; stage B combines the returned pattern with the crosshair.
// Assumes a synchronous pattern RAM with one clock of read latency and one
// pixel per clock.
module curs_overlay #(
    parameter int POS_W    = 12,
    parameter int CURS_DIM = 64,
    parameter int PIX_BITS = 2,
    parameter int WORD_W   = 16,
    parameter int PPW      = WORD_W / PIX_BITS,
    parameter int ADDR_W   = 2 * $clog2(CURS_DIM) - $clog2(PPW)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [POS_W-1:0]    pix_x,
    input  logic [POS_W-1:0]    pix_y,
    input  logic [6:0]          cmd,
    input  logic [POS_W-1:0]    cur_x,
    input  logic [POS_W-1:0]    cur_y,
    input  logic [POS_W-1:0]    win_x,
    input  logic [POS_W-1:0]    win_y,
    input  logic [POS_W-1:0]    win_w,
    input  logic [POS_W-1:0]    win_h,
    output logic [ADDR_W-1:0]   ram_addr,
    input  logic [WORD_W-1:0]   ram_data,
    output logic [PIX_BITS-1:0] cur_pix,
    output logic                xhair
);
    localparam int SW      = POS_W + 2;
    localparam int LOG_PPW = $clog2(PPW);

    curs_ovl_pkg::ovl_cmd_t ctl;
    logic signed [SW-1:0]   dx, dy;
    logic                   in_box, xh_hit;
    logic [LOG_PPW-1:0]     sub;

    logic                   a_cur, a_xh, a_or;
    logic [LOG_PPW-1:0]     a_sub;

    // Decode the command field into named controls.
    always_comb ctl = curs_ovl_pkg::decode_cmd(cmd);

    curs_place #(
        .POS_W(POS_W), .DIM(CURS_DIM), .PPW(PPW), .SW(SW), .ADDR_W(ADDR_W)
    ) u_place (
        .pix_x(pix_x), .pix_y(pix_y), .cur_x(cur_x), .cur_y(cur_y),
        .mux(ctl.mux), .dx(dx), .dy(dy), .in_box(in_box),
        .addr(ram_addr), .sub(sub)
    );

    curs_xhair #(
        .POS_W(POS_W), .DIM(CURS_DIM), .SW(SW)
    ) u_xhair (
        .pix_x(pix_x), .pix_y(pix_y), .dx(dx), .dy(dy), .half(ctl.half),
        .win_x(win_x), .win_y(win_y), .win_w(win_w), .win_h(win_h),
        .hit(xh_hit)
    );

    // Stage A register: aligns hit flags with the RAM word of the next clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_cur <= 1'b0;
            a_xh  <= 1'b0;
            a_or  <= 1'b0;
            a_sub <= '0;
        end else begin
            a_cur <= ctl.cur_on && in_box;
            a_xh  <= ctl.xh_on && xh_hit;
            a_or  <= ctl.or_mode;
            a_sub <= sub;
        end
    end

    curs_mix #(
        .PIX_BITS(PIX_BITS), .WORD_W(WORD_W), .PPW(PPW)
    ) u_mix (
        .clk(clk), .rst_n(rst_n), .s_cur(a_cur), .s_sub(a_sub),
        .s_xh(a_xh), .s_or(a_or), .ram_data(ram_data),
        .cur_pix(cur_pix), .xhair(xhair)
    );

endmodule

// File: rtl/curs_overlay_chk.sv
// Module: curs_overlay_chk
// Assertion checker for curs_overlay, bound to every instance of the top.
// Assumes the two-clock input-to-output latency of the top.
module curs_overlay_chk #(
    parameter int POS_W    = 12,
    parameter int PIX_BITS = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic [6:0]          cmd,
    input logic [POS_W-1:0]    win_w,
    input logic [POS_W-1:0]    win_h,
    input logic [PIX_BITS-1:0] cur_pix,
    input logic                xhair
);
    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> (cur_pix == '0 && !xhair)) else $error("reset state"); // R1
    AST_CURSOR_GATED: assert property (@(posedge clk) disable iff (!rst_n) !$past(cmd[6], 2) |-> cur_pix == '0) else $error("cursor off"); // R5
    AST_XHAIR_GATED: assert property (@(posedge clk) disable iff (!rst_n) !$past(cmd[5], 2) |-> !xhair) else $error("crosshair off"); // R6
    AST_EMPTY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n) ($past(win_w, 2) == '0 || $past(win_h, 2) == '0) |-> !xhair) else $error("empty window"); // R7
    AST_AND_XH_NEEDS_PIX: assert property (@(posedge clk) disable iff (!rst_n) (!$past(cmd[4], 2) && xhair) |-> cur_pix != '0) else $error("and mode xhair"); // R9
    AST_AND_PIX_NEEDS_XH: assert property (@(posedge clk) disable iff (!rst_n) (!$past(cmd[4], 2) && cur_pix != '0) |-> xhair) else $error("and mode pix"); // R9
endmodule

bind curs_overlay curs_overlay_chk #(.POS_W(POS_W), .PIX_BITS(PIX_BITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .win_w(win_w), .win_h(win_h),
    .cur_pix(cur_pix), .xhair(xhair)
);

// File: tb/curs_overlay_tb.sv
`timescale 1ns/1ps
// Bench for curs_overlay: behavioural reference model with a two-deep queue,
// compared on every clock; pattern RAM modelled with one clock latency.
module curs_overlay_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] pix_x = '0, pix_y = '0, cur_x = '0, cur_y = '0;
    logic [11:0] win_x = '0, win_y = '0, win_w = '0, win_h = '0;
    logic [6:0]  cmd = '0;
    logic [8:0]  ram_addr;
    logic [15:0] ram_data = '0;
    logic [1:0]  cur_pix;
    logic        xhair;

    always #5 clk = ~clk;

    curs_overlay u_dut (
        .clk(clk), .rst_n(rst_n), .pix_x(pix_x), .pix_y(pix_y), .cmd(cmd),
        .cur_x(cur_x), .cur_y(cur_y), .win_x(win_x), .win_y(win_y),
        .win_w(win_w), .win_h(win_h), .ram_addr(ram_addr),
        .ram_data(ram_data), .cur_pix(cur_pix), .xhair(xhair)
    );

    logic [15:0] mem [512];
    always @(posedge clk) ram_data <= mem[ram_addr];

    int n_chk = 0, n_fail = 0;
    int g_cmd, g_cx, g_cy, g_wx, g_wy, g_ww, g_wh;
    int q_p[$], q_h[$];
    string q_t[$];

    function automatic int x_off(int c);
        int m = (c >> 2) & 3;
        return (m == 1) ? 52 : ((m == 2) ? 57 : 37);
    endfunction

    function automatic void model(input int px, input int py, output int ep,
                                  output int eh, output int ea, output bit inb);
        int lx = g_cx - x_off(g_cmd);
        int ly = g_cy - 32;
        int dx = px - lx;
        int dy = py - ly;
        int c = 0, h, hx, hy;
        inb = (dx >= 0) && (dx < 64) && (dy >= 0) && (dy < 64);
        ea = inb ? dy * 8 + dx / 8 : 0;
        if (inb && ((g_cmd >> 6) & 1) == 1) c = (int'(mem[ea]) >> (2 * (7 - dx % 8))) & 3;
        hx = (dx - 32 < 0) ? 32 - dx : dx - 32;
        hy = (dy - 32 < 0) ? 32 - dy : dy - 32;
        h = (((g_cmd >> 5) & 1) == 1) && (hx <= (g_cmd & 3) || hy <= (g_cmd & 3))
            && px >= g_wx && px < g_wx + g_ww && py >= g_wy && py < g_wy + g_wh;
        if ((g_cmd & 16) != 0) begin
            ep = c; eh = h;
        end else begin
            ep = h ? c : 0; eh = (h != 0 && c != 0) ? 1 : 0;
        end
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One pixel clock: compare the result due now, then drive the next pixel.
    task automatic step(int px, int py, string tag);
        int ep, eh, ea;
        bit inb;
        @(negedge clk);
        if (q_p.size() == 2) begin
            string t = q_t.pop_front();
            chk({t, " R2 cur_pix"}, int'(cur_pix), q_p.pop_front());
            chk({t, " R2 xhair"}, int'(xhair), q_h.pop_front());
        end
        rst_n = 1'b1;
        pix_x = 12'(px); pix_y = 12'(py); cmd = 7'(g_cmd);
        cur_x = 12'(g_cx); cur_y = 12'(g_cy);
        win_x = 12'(g_wx); win_y = 12'(g_wy); win_w = 12'(g_ww); win_h = 12'(g_wh);
        model(px, py, ep, eh, ea, inb);
        #1;
        if (inb) chk({tag, " R4 ram_addr"}, int'(ram_addr), ea);
        q_p.push_back(ep); q_h.push_back(eh); q_t.push_back(tag);
    endtask

    // Sweep every pixel of the box plus a 4-pixel margin.
    task automatic scan(string tag);
        int lx = g_cx - x_off(g_cmd);
        int ly = g_cy - 32;
        for (int y = ly - 4; y < ly + 68; y++)
            for (int x = lx - 4; x < lx + 68; x++)
                if (x >= 0 && y >= 0 && x < 4096 && y < 4096) step(x, y, tag);
    endtask

    task automatic set_all(int c, int cx, int cy, int wx, int wy, int ww, int wh);
        g_cmd = c; g_cx = cx; g_cy = cy; g_wx = wx; g_wy = wy; g_ww = ww; g_wh = wh;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #1900000;
        n_chk++; n_fail++;
        $display("FAIL watchdog R2 actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 512; i++)
            mem[i] = (i % 5 == 0) ? 16'h0000 : 16'((i * 40503) ^ (i << 7) ^ 16'h5a3c);
        set_all(0, 0, 0, 0, 0, 0, 0);
        // R1: outputs held at zero during reset
        repeat (3) begin
            @(negedge clk);
            chk("R1 reset cur_pix", int'(cur_pix), 0);
            chk("R1 reset xhair", int'(xhair), 0);
        end
        // R3 R4 R5 R6 R8: 1:1 offset, thin crosshair, OR, full window
        set_all(7'h70, 400, 300, 0, 0, 4095, 4095);
        scan("R3 R4 R5 R6 R8 a");
        // R3 R6 R7 R8: 4:1 offset, 7-pixel bands, partial window
        set_all(7'h74 | 3, 500, 200, 460, 160, 30, 40);
        scan("R3 R6 R7 R8 b");
        // R3 R9: 5:1 offset, AND combination, 5-pixel bands
        set_all(7'h68 | 2, 600, 400, 0, 0, 4095, 4095);
        scan("R3 R9 c");
        // R3 R5 R6: reserved ratio acts as 1:1, cursor disabled
        set_all(7'h3c | 1, 300, 100, 0, 0, 4095, 4095);
        scan("R3 R5 R6 d");
        // R7: zero-width then zero-height window
        set_all(7'h70, 700, 500, 0, 0, 0, 4095);
        scan("R5 R7 e width");
        set_all(7'h70, 700, 500, 0, 0, 4095, 0);
        scan("R5 R7 e height");
        // R3 R5: box partly left of and above the raster origin
        set_all(7'h70, 10, 5, 0, 0, 4095, 4095);
        scan("R3 R5 f edge");
        // R1: reset in mid-run clears outputs
        @(negedge clk);
        rst_n = 1'b0;
        q_p.delete(); q_h.delete(); q_t.delete();
        repeat (2) begin
            @(negedge clk);
            chk("R1 midrun cur_pix", int'(cur_pix), 0);
            chk("R1 midrun xhair", int'(xhair), 0);
        end
        // R2 R8 R9: commands, positions and window change under way
        for (int k = 0; k < 3000; k++) begin
            int lx;
            if (k % 8 == 0)
                set_all(int'($urandom % 128), 100 + int'($urandom % 200), 100 + int'($urandom % 200),
                        int'($urandom % 300), int'($urandom % 300),
                        int'($urandom % 120), int'($urandom % 120));
            lx = g_cx - x_off(g_cmd);
            step(lx - 8 + int'($urandom % 80), g_cy - 40 + int'($urandom % 80), "R2 R8 R9 rand");
        end
        step(0, 0, "R2 drain");
        step(0, 0, "R2 drain");
        @(negedge clk);
        summary();
        $finish;
    end
endmodule